// File: doc/BRIEF.md
# Receive Packet Acknowledge Controller

This block follows inbound packets on the receive side of a serial link and decides, for each one, which acknowledgement the transmit side should send back. It keeps the acknowledgement ID that the next packet must carry. While a packet is in flight it checks three things: whether the packet's ackID matches, whether the running byte count has grown past the payload limit, and whether the CRC is good. A packet that passes all three checks gets an accepted request, and the expected ID advances.

The first error sends the block into a stopped state. It raises a single not-accepted request that carries a cause code, and it pulses `discard` so the user side drops the packet. After that, every new packet is dropped quietly: the block raises no request for it and only pulses `discard` when the packet ends. A restart strobe from the link partner returns the block to normal operation. At that point it issues a link-response request that carries the current expected ID.

All outputs are registered and appear one clock after the input cycle that causes them. Reset is synchronous and active high.

Top module: `rx_pkt_ack_ctrl`

## Requirements
- R1: After reset, `ack_req`, `discard`, `stopped` and `ack_cause` are 0, and the expected ackID is 0.
- R2: A packet whose ackID matches, whose CRC is good and whose size is within the limit produces one `ack_req` with `ack_type`=0 (accepted) and `ack_id` equal to the expected ID, one cycle after its end beat. The expected ID then increments modulo 2^ID_W. Back-to-back packets are each acknowledged.
- R3: An ackID at the start beat that differs from the expected ID produces, one cycle later, `ack_req` with `ack_type`=1 (not accepted) and `ack_cause`=1, a `discard` pulse, and `stopped`=1.
- R4: A CRC-bad flag on the end beat produces `ack_type`=1 with `ack_cause`=2, plus `discard` and `stopped`, one cycle later.
- R5: In the cycle in which the running byte count of a packet first exceeds MAX_BYTES, an error is raised. One cycle later the block outputs `ack_type`=1 with `ack_cause`=3, plus `discard` and `stopped`, even if the packet has not yet ended.
- R6: When several errors occur in the same cycle, the lowest cause code wins: ackID, then CRC, then overrun.
- R7: After a packet has errored, its remaining beats and its end beat produce no further request and no further `discard`.
- R8: A packet that starts while the block is stopped produces no `ack_req`. It pulses `discard` one cycle after its end beat and leaves the expected ID unchanged.
- R9: `restart_strb` while stopped returns the block to normal one cycle later and issues `ack_req` with `ack_type`=2 (link response) and `ack_id` equal to the expected ID.
- R10: `restart_strb` in the normal state has no effect on any output or on the expected ID.
- R11: A packet that started while the block was stopped is still dropped when a restart arrives before its end beat.
- R12: A packet of exactly MAX_BYTES bytes is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_sof | input | 1 | First beat of a packet |
| pkt_eof | input | 1 | Last beat of a packet (may coincide with pkt_sof) |
| pkt_ackid | input | ID_W | Packet ackID, sampled on the start beat |
| pkt_bytes_vld | input | 1 | pkt_bytes is valid this beat |
| pkt_bytes | input | BEAT_W | Payload bytes in this beat (0..BEAT_BYTES) |
| pkt_crc_bad | input | 1 | CRC failed, sampled on the end beat |
| restart_strb | input | 1 | Restart-from-error indication received |
| ack_req | output | 1 | Acknowledgement request pulse |
| ack_type | output | 2 | 0 accepted, 1 not accepted, 2 link response |
| ack_id | output | ID_W | ackID carried by the request |
| ack_cause | output | 2 | Not-accepted cause: 1 ackID, 2 CRC, 3 overrun; otherwise 0 |
| discard | output | 1 | Drop the current or just-finished packet |
| stopped | output | 1 | Block is in the input-error-stopped state |

## Verification
A wrong expected ID shows up at the very next accepted or link-response request, because `ack_id` no longer follows the count of accepted packets. A stuck or missed stopped state shows up one cycle after the next packet end: either an accepted request appears where none should, or an expected `discard` pulse is missing. A byte counter that is not cleared between packets shows up as a cause-3 rejection on the first packet that follows a long one.

// File: rtl/rxack_pkg.sv
package rxack_pkg;
  typedef enum logic [1:0] {
    ACK_ACCEPT   = 2'd0,
    ACK_REJECT   = 2'd1,
    ACK_LINKRESP = 2'd2
  } ack_kind_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_STOP = 1'b1
  } rx_state_e;

  localparam logic [1:0] CAUSE_NONE = 2'd0;
  localparam logic [1:0] CAUSE_ID   = 2'd1;
  localparam logic [1:0] CAUSE_CRC  = 2'd2;
  localparam logic [1:0] CAUSE_OVR  = 2'd3;
endpackage

// File: rtl/rxack_len_track.sv
module rxack_len_track #(
  parameter int MAX_BYTES  = 256,
  parameter int BEAT_BYTES = 8,
  localparam int BEAT_W = $clog2(BEAT_BYTES + 1),
  localparam int CNT_W  = $clog2(MAX_BYTES + BEAT_BYTES + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              act,
  input  logic              bytes_vld,
  input  logic [BEAT_W-1:0] bytes,
  output logic              overrun
);
  logic [CNT_W-1:0] cnt_q, base, sum;

  always_comb begin
    base    = sof ? '0 : cnt_q;
    sum     = base + (bytes_vld ? CNT_W'(bytes) : '0);
    overrun = act & (sum > CNT_W'(MAX_BYTES));
  end

  // count saturates one above the limit once exceeded
  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (act) cnt_q <= overrun ? CNT_W'(MAX_BYTES + 1) : sum;
  end

  assert_cnt_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(MAX_BYTES + 1));
endmodule

// File: rtl/rxack_err_sel.sv
module rxack_err_sel #(
  parameter int ID_W = 5
) (
  input  logic            chk,
  input  logic            sof,
  input  logic            eof,
  input  logic [ID_W-1:0] pkt_id,
  input  logic [ID_W-1:0] exp_id,
  input  logic            crc_bad,
  input  logic            overrun,
  output logic            err,
  output logic [1:0]      cause
);
  import rxack_pkg::*;

  // lowest cause code has priority
  always_comb begin
    if (sof && (pkt_id != exp_id)) cause = CAUSE_ID;
    else if (eof && crc_bad)       cause = CAUSE_CRC;
    else if (overrun)              cause = CAUSE_OVR;
    else                           cause = CAUSE_NONE;
    err = chk & (cause != CAUSE_NONE);
  end
endmodule

// File: rtl/rxack_ctrl.sv
module rxack_ctrl #(
  parameter int ID_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sof,
  input  logic            eof,
  input  logic            restart,
  input  logic            err,
  input  logic [1:0]      cause,
  output logic            act_o,
  output logic            chk_o,
  output logic [ID_W-1:0] exp_id_o,
  output logic            ack_req_o,
  output logic [1:0]      ack_type_o,
  output logic [ID_W-1:0] ack_id_o,
  output logic [1:0]      ack_cause_o,
  output logic            discard_o,
  output logic            stopped_o
);
  import rxack_pkg::*;

  rx_state_e       st_q;
  logic            in_q, ign_q, dead_q;
  logic            ign, dead;
  logic [ID_W-1:0] exp_q;

  // ign: packet began while stopped; dead: packet already rejected
  always_comb begin
    act_o    = sof | in_q;
    ign      = sof ? (st_q == ST_STOP) : ign_q;
    dead     = sof ? 1'b0 : dead_q;
    chk_o    = act_o & ~ign & ~dead;
    exp_id_o = exp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_RUN;
      in_q        <= 1'b0;
      ign_q       <= 1'b0;
      dead_q      <= 1'b0;
      exp_q       <= '0;
      ack_req_o   <= 1'b0;
      ack_type_o  <= ACK_ACCEPT;
      ack_id_o    <= '0;
      ack_cause_o <= CAUSE_NONE;
      discard_o   <= 1'b0;
    end else begin
      ack_req_o   <= 1'b0;
      ack_type_o  <= ACK_ACCEPT;
      ack_id_o    <= exp_q;
      ack_cause_o <= CAUSE_NONE;
      discard_o   <= 1'b0;
      in_q        <= act_o & ~eof;
      if (act_o) begin
        ign_q  <= ign;
        dead_q <= dead | (chk_o & err);
      end
      if ((st_q == ST_STOP) && restart) begin
        st_q       <= ST_RUN;
        ack_req_o  <= 1'b1;
        ack_type_o <= ACK_LINKRESP;
      end
      if (chk_o && err) begin
        st_q        <= ST_STOP;
        ack_req_o   <= 1'b1;
        ack_type_o  <= ACK_REJECT;
        ack_cause_o <= cause;
        discard_o   <= 1'b1;
      end else if (chk_o && eof) begin
        ack_req_o  <= 1'b1;
        ack_type_o <= ACK_ACCEPT;
        exp_q      <= exp_q + 1'b1;
      end
      if (act_o && ign && eof) discard_o <= 1'b1;
    end
  end

  assign stopped_o = (st_q == ST_STOP);

  assert_reject_stops_R3: assert property (@(posedge clk) disable iff (rst)
    (ack_req_o && ack_type_o == ACK_REJECT) |-> stopped_o && discard_o);
  assert_stop_entry_once_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(stopped_o) |-> ack_req_o && ack_type_o == ACK_REJECT);
  assert_restart_linkresp_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(stopped_o) |-> ack_req_o && ack_type_o == ACK_LINKRESP);
  assert_no_accept_stopped_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_req_o && ack_type_o == ACK_ACCEPT) |-> !stopped_o);
  assert_id_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (ack_req_o && ack_type_o == ACK_ACCEPT) |-> exp_q == ack_id_o + 1'b1);
endmodule

// File: rtl/rx_pkt_ack_ctrl.sv
module rx_pkt_ack_ctrl #(
  parameter int ID_W       = 5,
  parameter int MAX_BYTES  = 256,
  parameter int BEAT_BYTES = 8,
  localparam int BEAT_W = $clog2(BEAT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_sof,
  input  logic              pkt_eof,
  input  logic [ID_W-1:0]   pkt_ackid,
  input  logic              pkt_bytes_vld,
  input  logic [BEAT_W-1:0] pkt_bytes,
  input  logic              pkt_crc_bad,
  input  logic              restart_strb,
  output logic              ack_req,
  output logic [1:0]        ack_type,
  output logic [ID_W-1:0]   ack_id,
  output logic [1:0]        ack_cause,
  output logic              discard,
  output logic              stopped
);
  logic            act, chk, overrun, err;
  logic [1:0]      cause;
  logic [ID_W-1:0] exp_id;

  rxack_len_track #(.MAX_BYTES(MAX_BYTES), .BEAT_BYTES(BEAT_BYTES)) u_len (
    .clk(clk), .rst(rst), .sof(pkt_sof), .act(act),
    .bytes_vld(pkt_bytes_vld), .bytes(pkt_bytes), .overrun(overrun)
  );

  rxack_err_sel #(.ID_W(ID_W)) u_err (
    .chk(chk), .sof(pkt_sof), .eof(pkt_eof), .pkt_id(pkt_ackid),
    .exp_id(exp_id), .crc_bad(pkt_crc_bad), .overrun(overrun),
    .err(err), .cause(cause)
  );

  rxack_ctrl #(.ID_W(ID_W)) u_ctrl (
    .clk(clk), .rst(rst), .sof(pkt_sof), .eof(pkt_eof),
    .restart(restart_strb), .err(err), .cause(cause),
    .act_o(act), .chk_o(chk), .exp_id_o(exp_id),
    .ack_req_o(ack_req), .ack_type_o(ack_type), .ack_id_o(ack_id),
    .ack_cause_o(ack_cause), .discard_o(discard), .stopped_o(stopped)
  );
endmodule

// File: tb/sim_rx_pkt_ack_ctrl.sv
module sim_rx_pkt_ack_ctrl;
  localparam int MAXB = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pkt_sof = 0, pkt_eof = 0, pkt_bytes_vld = 0, pkt_crc_bad = 0, restart_strb = 0;
  logic [4:0] pkt_ackid = '0;
  logic [3:0] pkt_bytes = '0;
  logic       ack_req, discard, stopped;
  logic [1:0] ack_type, ack_cause;
  logic [4:0] ack_id;

  int n_chk = 0, n_err = 0, cyc = 0;

  // bench reference state
  logic [4:0] m_exp = '0;
  bit m_stop = 0, m_in = 0, m_ign = 0, m_dead = 0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  rx_pkt_ack_ctrl u0 (
    .clk(clk), .rst(rst), .pkt_sof(pkt_sof), .pkt_eof(pkt_eof), .pkt_ackid(pkt_ackid),
    .pkt_bytes_vld(pkt_bytes_vld), .pkt_bytes(pkt_bytes), .pkt_crc_bad(pkt_crc_bad),
    .restart_strb(restart_strb), .ack_req(ack_req), .ack_type(ack_type), .ack_id(ack_id),
    .ack_cause(ack_cause), .discard(discard), .stopped(stopped)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic check(input string tag, input bit rq, input [1:0] ty, input [4:0] id,
                       input [1:0] ca, input bit di, input bit st);
    bit bad;
    n_chk++;
    bad = (ack_req !== rq) || (ack_cause !== ca) || (discard !== di) || (stopped !== st) ||
          (rq && ((ack_type !== ty) || (ack_id !== id)));
    if (bad) begin
      n_err++;
      $display("FAIL %s: actual req=%b type=%0d id=%0d cause=%0d disc=%b stop=%b expected req=%b type=%0d id=%0d cause=%0d disc=%b stop=%b",
               tag, ack_req, ack_type, ack_id, ack_cause, discard, stopped, rq, ty, id, ca, di, st);
    end
  endtask

  // one beat: drive, predict from the requirements, sample at the next falling edge
  task automatic step(input bit s, input bit e, input [4:0] id, input int nb,
                      input bit crc, input bit rs, input string tag);
    bit act, ign, dead, chk, ovr, rq, di, nstop;
    int sum;
    logic [1:0] ca, ty, ec;
    logic [4:0] eid;
    pkt_sof = s; pkt_eof = e; pkt_ackid = id; pkt_bytes_vld = (nb > 0);
    pkt_bytes = 4'(nb); pkt_crc_bad = crc; restart_strb = rs;
    act = s || m_in; ign = s ? m_stop : m_ign; dead = s ? 0 : m_dead;
    chk = act && !ign && !dead;
    sum = (s ? 0 : m_cnt) + nb;
    ovr = act && (sum > MAXB);
    ec = (s && id != m_exp) ? 2'd1 : (e && crc) ? 2'd2 : ovr ? 2'd3 : 2'd0;
    rq = 0; ty = 0; ca = 0; di = 0; eid = m_exp; nstop = m_stop;
    if (m_stop && rs) begin rq = 1; ty = 2; nstop = 0; end
    if (chk && ec != 0) begin rq = 1; ty = 1; ca = ec; di = 1; nstop = 1; end
    else if (chk && e) begin rq = 1; ty = 0; m_exp = m_exp + 1; end
    if (act && ign && e) di = 1;
    if (act) begin
      m_cnt = ovr ? MAXB + 1 : sum;
      m_ign = ign; m_dead = dead || (chk && ec != 0);
    end
    m_in = act && !e;
    m_stop = nstop;
    @(posedge clk); @(negedge clk);
    check(tag, rq, ty, eid, ca, di, m_stop);
  endtask

  task automatic idle(input int n, input bit rs, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 5'd0, 0, 0, rs && i == 0, tag);
  endtask

  task automatic pkt(input [4:0] id, input int len, input bit crc, input int rs_beat,
                     input string tag);
    int rem, nb;
    rem = len;
    for (int b = 0; rem > 0; b++) begin
      nb = 1 + int'($urandom % 8);
      if (nb > rem) nb = rem;
      rem = rem - nb;
      step(b == 0, rem == 0, id, nb, crc && rem == 0, b == rs_beat, tag);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 0, 0, 0, 0, 0, 0);
    // R2 back-to-back good packets
    pkt(m_exp, 20, 0, -1, "R2");
    pkt(m_exp, 9, 0, -1, "R2");
    idle(2, 0, "R2");
    // R12 exactly at the limit
    pkt(m_exp, MAXB, 0, -1, "R12");
    // R10 restart in normal state
    idle(2, 1, "R10");
    pkt(m_exp, 12, 0, -1, "R10");
    // R3 wrong ackID, then R8 three dropped packets
    pkt(m_exp + 5'd7, 30, 0, -1, "R3");
    for (int k = 0; k < 3; k++) pkt(m_exp, 10 + 20 * k, 0, -1, "R8");
    idle(2, 1, "R9");
    pkt(m_exp, 40, 1, -1, "R4");
    idle(2, 1, "R9");
    // R5 overrun before end, R7 rest of packet silent
    pkt(m_exp, 300, 0, -1, "R5/R7");
    idle(2, 1, "R9");
    // R6 single beat, bad id and bad CRC together: id wins
    step(1, 1, m_exp + 5'd1, 4, 1, 0, "R6");
    // R11 restart arrives mid-way through a dropped packet
    pkt(m_exp, 40, 0, 1, "R11");
    pkt(m_exp, 16, 0, -1, "R11");
    // constrained random traffic
    for (int n = 0; n < 300; n++) begin
      pkt(($urandom % 10 == 0) ? m_exp + 5'd1 : m_exp, 1 + int'($urandom % 280),
          ($urandom % 12 == 0), -1, "R2/R8");
      idle(int'($urandom % 3), ($urandom % 3 == 0), "R9");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule